// File: doc/BRIEF.md
# Runahead Validity Tracker

This block keeps the poison state of a core that keeps running while it waits on a long cache miss. When the oldest load misses, the core enters a speculative mode. In that mode every physical register and every store-buffer slot carries one validity flag. A result that depends on the missing data is flagged as bogus. The flag spreads to every consumer, and the core never waits for flagged work.

An instruction is checked at issue. It is flagged if a source register it reads is flagged. A load that forwards from a flagged store-buffer slot is also flagged. A flagged instruction flags its destination register. A flagged store flags its store-buffer slot. A valid writeback clears the flag of its destination register, and a valid store writeback clears the flag of its slot.

At the head of the window, a flagged instruction leaves at once. The load that started the mode also leaves at once. A valid instruction leaves only once it has executed. Nothing that leaves in speculative mode touches architectural state. On exit, every flag is cleared, and for one drain cycle the pipeline is flushed.

The mode machine has three states. NORMAL goes to RUNAHEAD on `ra_enter`. RUNAHEAD goes to DRAIN on `ra_exit`. DRAIN goes to NORMAL unconditionally after one cycle.

Top module: `ra_validity_tracker`

## Requirements
- R1: After reset the state is NORMAL and `ra_active` is 0. `ra_enter` in NORMAL makes `ra_active` 1 from the next cycle. `ra_exit` in RUNAHEAD leads to DRAIN for exactly one cycle, and then to NORMAL. `ra_active` is 1 only in RUNAHEAD.
- R2: On the edge that accepts `ra_enter`, the register named by `trig_tag` becomes flagged.
- R3: In RUNAHEAD, `iss_inv` is 1 in the same cycle when `iss_valid` is 1 and a source whose `_used` bit is 1 names a flagged register. A source whose `_used` bit is 0 has no effect. When `iss_inv` is 1 and `iss_dst_we` is 1, the destination register is flagged from the next cycle.
- R4: An issue with `iss_inv` at 0 leaves its destination register unflagged. A writeback with `wb_valid` and `wb_dst_we` at 1 clears the flag of `wb_dst_tag` from the next cycle.
- R5: An issue with `iss_is_store` at 1 and `iss_inv` at 1 flags store slot `iss_sb_idx` from the next cycle. A writeback with `wb_is_store` at 1 clears the flag of slot `wb_sb_idx` from the next cycle.
- R6: In RUNAHEAD, an issue with `iss_fwd` at 1 whose slot `iss_sb_idx` is flagged gives `iss_inv` = 1.
- R7: In RUNAHEAD, with `head_valid` at 1, a head entry with `head_inv` at 1 pops in the same cycle. An unflagged head entry pops only when `head_done` is 1.
- R8: The first head entry seen in RUNAHEAD is the triggering load. It pops at once, whatever its `head_inv` and `head_done` are.
- R9: In RUNAHEAD every pop raises `head_pseudo` and never `head_commit`. In NORMAL, a pop needs `head_done`, raises `head_commit`, and ignores `head_inv`.
- R10: Leaving RUNAHEAD clears every register flag and every store-slot flag.
- R11: In DRAIN, `head_pop` stays 0.
- R12: Outside RUNAHEAD, `iss_inv` is 0 and no flag is set.
- R13: At most one entry leaves per cycle, and `head_commit` and `head_pseudo` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ra_enter | input | 1 | Blocking miss at head: start speculative mode |
| ra_exit | input | 1 | Miss data returned: leave speculative mode |
| trig_tag | input | TAG_W | Destination register of the triggering load |
| ra_active | output | 1 | 1 while in RUNAHEAD |
| iss_valid | input | 1 | An instruction issues this cycle |
| iss_src0_used | input | 1 | Source 0 is read |
| iss_src0_tag | input | TAG_W | Source 0 register |
| iss_src1_used | input | 1 | Source 1 is read |
| iss_src1_tag | input | TAG_W | Source 1 register |
| iss_dst_we | input | 1 | Instruction writes a register |
| iss_dst_tag | input | TAG_W | Destination register |
| iss_is_store | input | 1 | Instruction is a store into slot `iss_sb_idx` |
| iss_fwd | input | 1 | Load forwards from slot `iss_sb_idx` |
| iss_sb_idx | input | SB_W | Store-buffer slot |
| iss_inv | output | 1 | Issued instruction is flagged |
| wb_valid | input | 1 | A valid result is written back |
| wb_dst_we | input | 1 | Writeback targets a register |
| wb_dst_tag | input | TAG_W | Writeback register |
| wb_is_store | input | 1 | Writeback is a valid store execution |
| wb_sb_idx | input | SB_W | Slot of that store |
| head_valid | input | 1 | Window head holds an entry |
| head_inv | input | 1 | Head entry was flagged at issue |
| head_done | input | 1 | Head entry has executed |
| head_pop | output | 1 | Head entry leaves this cycle |
| head_commit | output | 1 | Leaves with architectural update |
| head_pseudo | output | 1 | Leaves without architectural update |

## Verification
The assertions check these rules on every cycle:
- a flagged used source always yields a flagged issue;
- no flag is reported outside RUNAHEAD;
- commit and pseudo-retire are exclusive and tied to the mode;
- a pop in NORMAL needs an executed entry;
- an exit always lands in DRAIN;
- nothing pops in DRAIN.

Only the directed scenarios can show the rest:
- flags reach later consumers one cycle after issue;
- a writeback makes a register or store slot valid again;
- the triggering load leaves first;
- the exit wipes both flag arrays, which shows once the mode is entered again.

// File: rtl/ra_validity_pkg.sv
package ra_validity_pkg;

    typedef enum logic [1:0] {
        ST_NORMAL   = 2'd0,
        ST_RUNAHEAD = 2'd1,
        ST_DRAIN    = 2'd2
    } ra_state_e;

endpackage

// File: rtl/ra_inv_bits.sv
module ra_inv_bits #(
    parameter int N = 64,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          set_en,
    input  logic [IW-1:0] set_idx,
    input  logic          clr_en,
    input  logic [IW-1:0] clr_idx,
    output logic [N-1:0]  bits
);

    // flush beats set, set beats clear
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bits[i] <= 1'b0;
            end else if (flush) begin
                bits[i] <= 1'b0;
            end else if (set_en && (set_idx == IW'(i))) begin
                bits[i] <= 1'b1;
            end else if (clr_en && (clr_idx == IW'(i))) begin
                bits[i] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/ra_mode_fsm.sv
module ra_mode_fsm
    import ra_validity_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      enter,
    input  logic      leave,
    input  logic      popped,
    output ra_state_e state,
    output logic      trig_pend,
    output logic      flush
);

    ra_state_e state_nx;
    logic      trig_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_NORMAL;
            trig_pend <= 1'b0;
        end else begin
            state     <= state_nx;
            trig_pend <= trig_nx;
        end
    end

    always_comb begin
        state_nx = state;
        trig_nx  = trig_pend;
        flush    = 1'b0;
        unique case (state)
            ST_NORMAL: begin
                if (enter) begin
                    state_nx = ST_RUNAHEAD;
                    trig_nx  = 1'b1;
                end
            end
            ST_RUNAHEAD: begin
                if (popped) trig_nx = 1'b0;
                if (leave) begin
                    state_nx = ST_DRAIN;
                    trig_nx  = 1'b0;
                    flush    = 1'b1;
                end
            end
            ST_DRAIN: begin
                state_nx = ST_NORMAL;
            end
            default: begin
                state_nx = ST_NORMAL;
                trig_nx  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/ra_head_ctl.sv
module ra_head_ctl
    import ra_validity_pkg::*;
(
    input  ra_state_e state,
    input  logic      trig_pend,
    input  logic      head_valid,
    input  logic      head_inv,
    input  logic      head_done,
    output logic      pop,
    output logic      commit,
    output logic      pseudo
);

    always_comb begin
        pop    = 1'b0;
        commit = 1'b0;
        pseudo = 1'b0;
        unique case (state)
            ST_NORMAL: begin
                commit = head_valid && head_done;
                pop    = commit;
            end
            ST_RUNAHEAD: begin
                pseudo = head_valid && (head_inv || head_done || trig_pend);
                pop    = pseudo;
            end
            ST_DRAIN: begin
                pop = 1'b0;
            end
            default: begin
                pop = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/ra_validity_tracker.sv
module ra_validity_tracker
    import ra_validity_pkg::*;
#(
    parameter int NPREG = 64,
    parameter int NSB   = 16,
    localparam int TAG_W = $clog2(NPREG),
    localparam int SB_W  = $clog2(NSB)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ra_enter,
    input  logic             ra_exit,
    input  logic [TAG_W-1:0] trig_tag,
    output logic             ra_active,
    input  logic             iss_valid,
    input  logic             iss_src0_used,
    input  logic [TAG_W-1:0] iss_src0_tag,
    input  logic             iss_src1_used,
    input  logic [TAG_W-1:0] iss_src1_tag,
    input  logic             iss_dst_we,
    input  logic [TAG_W-1:0] iss_dst_tag,
    input  logic             iss_is_store,
    input  logic             iss_fwd,
    input  logic [SB_W-1:0]  iss_sb_idx,
    output logic             iss_inv,
    input  logic             wb_valid,
    input  logic             wb_dst_we,
    input  logic [TAG_W-1:0] wb_dst_tag,
    input  logic             wb_is_store,
    input  logic [SB_W-1:0]  wb_sb_idx,
    input  logic             head_valid,
    input  logic             head_inv,
    input  logic             head_done,
    output logic             head_pop,
    output logic             head_commit,
    output logic             head_pseudo
);

    ra_state_e        state;
    logic             trig_pend;
    logic             flush;
    logic             in_ra;
    logic [NPREG-1:0] reg_inv;
    logic [NSB-1:0]   sb_inv;
    logic             reg_set;
    logic [TAG_W-1:0] reg_set_idx;
    logic             reg_clr;
    logic             sb_set;
    logic             sb_clr;

    ra_mode_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .enter     (ra_enter),
        .leave     (ra_exit),
        .popped    (head_pop),
        .state     (state),
        .trig_pend (trig_pend),
        .flush     (flush)
    );

    assign in_ra     = (state == ST_RUNAHEAD);
    assign ra_active = in_ra;

    // issue-side poison check
    always_comb begin
        iss_inv = 1'b0;
        if (in_ra && iss_valid) begin
            iss_inv = (iss_src0_used && reg_inv[iss_src0_tag])
                   || (iss_src1_used && reg_inv[iss_src1_tag])
                   || (iss_fwd && sb_inv[iss_sb_idx]);
        end
    end

    always_comb begin
        if (state == ST_NORMAL) begin
            reg_set     = ra_enter;
            reg_set_idx = trig_tag;
        end else begin
            reg_set     = in_ra && iss_valid && iss_dst_we && iss_inv;
            reg_set_idx = iss_dst_tag;
        end
    end

    assign reg_clr = in_ra && wb_valid && wb_dst_we;
    assign sb_set  = in_ra && iss_valid && iss_is_store && iss_inv;
    assign sb_clr  = in_ra && wb_valid && wb_is_store;

    ra_inv_bits #(.N(NPREG)) u_reg_bits (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .set_en  (reg_set),
        .set_idx (reg_set_idx),
        .clr_en  (reg_clr),
        .clr_idx (wb_dst_tag),
        .bits    (reg_inv)
    );

    ra_inv_bits #(.N(NSB)) u_sb_bits (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .set_en  (sb_set),
        .set_idx (iss_sb_idx),
        .clr_en  (sb_clr),
        .clr_idx (wb_sb_idx),
        .bits    (sb_inv)
    );

    ra_head_ctl u_head (
        .state      (state),
        .trig_pend  (trig_pend),
        .head_valid (head_valid),
        .head_inv   (head_inv),
        .head_done  (head_done),
        .pop        (head_pop),
        .commit     (head_commit),
        .pseudo     (head_pseudo)
    );

endmodule

// File: rtl/ra_validity_checker.sv
module ra_validity_checker #(
    parameter int NPREG = 64,
    localparam int TAG_W = $clog2(NPREG)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ra_active,
    input logic             ra_exit,
    input logic             iss_valid,
    input logic             iss_src0_used,
    input logic [TAG_W-1:0] iss_src0_tag,
    input logic             iss_inv,
    input logic [NPREG-1:0] reg_inv,
    input logic             head_valid,
    input logic             head_done,
    input logic             head_pop,
    input logic             head_commit,
    input logic             head_pseudo
);

    assert_exit_leaves_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ra_active && ra_exit) |=> !ra_active);

    assert_drain_no_pop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ra_active && ra_exit) |=> !head_pop);

    assert_poison_spreads_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ra_active && iss_valid && iss_src0_used && reg_inv[iss_src0_tag]) |-> iss_inv);

    assert_quiet_outside_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !ra_active |-> !iss_inv);

    assert_pseudo_in_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
        head_pseudo |-> ra_active);

    assert_commit_needs_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        head_commit |-> (!ra_active && head_done && head_valid));

    assert_single_leave_R13: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({head_commit, head_pseudo}));

    assert_pop_needs_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        head_pop |-> head_valid);

endmodule

bind ra_validity_tracker ra_validity_checker #(.NPREG(NPREG)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ra_active     (ra_active),
    .ra_exit       (ra_exit),
    .iss_valid     (iss_valid),
    .iss_src0_used (iss_src0_used),
    .iss_src0_tag  (iss_src0_tag),
    .iss_inv       (iss_inv),
    .reg_inv       (reg_inv),
    .head_valid    (head_valid),
    .head_done     (head_done),
    .head_pop      (head_pop),
    .head_commit   (head_commit),
    .head_pseudo   (head_pseudo)
);

// File: tb/ra_validity_tracker_bench.sv
module ra_validity_tracker_bench;

    localparam int NPREG = 64;
    localparam int NSB   = 16;
    localparam int TW    = $clog2(NPREG);
    localparam int SW    = $clog2(NSB);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ra_enter = 1'b0, ra_exit = 1'b0;
    logic [TW-1:0] trig_tag = '0;
    logic          ra_active;
    logic          iss_valid = 1'b0, iss_src0_used = 1'b0, iss_src1_used = 1'b0;
    logic [TW-1:0] iss_src0_tag = '0, iss_src1_tag = '0, iss_dst_tag = '0;
    logic          iss_dst_we = 1'b0, iss_is_store = 1'b0, iss_fwd = 1'b0;
    logic [SW-1:0] iss_sb_idx = '0;
    logic          iss_inv;
    logic          wb_valid = 1'b0, wb_dst_we = 1'b0, wb_is_store = 1'b0;
    logic [TW-1:0] wb_dst_tag = '0;
    logic [SW-1:0] wb_sb_idx = '0;
    logic          head_valid = 1'b0, head_inv = 1'b0, head_done = 1'b0;
    logic          head_pop, head_commit, head_pseudo;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    ra_validity_tracker #(.NPREG(NPREG), .NSB(NSB)) u_ra_validity_tracker (
        .clk(clk), .rst_n(rst_n), .ra_enter(ra_enter), .ra_exit(ra_exit),
        .trig_tag(trig_tag), .ra_active(ra_active),
        .iss_valid(iss_valid), .iss_src0_used(iss_src0_used), .iss_src0_tag(iss_src0_tag),
        .iss_src1_used(iss_src1_used), .iss_src1_tag(iss_src1_tag),
        .iss_dst_we(iss_dst_we), .iss_dst_tag(iss_dst_tag), .iss_is_store(iss_is_store),
        .iss_fwd(iss_fwd), .iss_sb_idx(iss_sb_idx), .iss_inv(iss_inv),
        .wb_valid(wb_valid), .wb_dst_we(wb_dst_we), .wb_dst_tag(wb_dst_tag),
        .wb_is_store(wb_is_store), .wb_sb_idx(wb_sb_idx),
        .head_valid(head_valid), .head_inv(head_inv), .head_done(head_done),
        .head_pop(head_pop), .head_commit(head_commit), .head_pseudo(head_pseudo)
    );

    task automatic check(string req, string what, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic idle_issue();
        iss_valid = 0; iss_src0_used = 0; iss_src1_used = 0; iss_dst_we = 0;
        iss_is_store = 0; iss_fwd = 0;
        wb_valid = 0; wb_dst_we = 0; wb_is_store = 0;
    endtask

    task automatic next();
        @(negedge clk);
        idle_issue();
    endtask

    // combinational probe of a register flag through the issue port
    task automatic probe_reg(input logic [TW-1:0] t, output logic r);
        iss_valid = 1; iss_src0_used = 1; iss_src0_tag = t;
        #1 r = iss_inv;
        idle_issue();
    endtask

    task automatic probe_sb(input logic [SW-1:0] s, output logic r);
        iss_valid = 1; iss_fwd = 1; iss_sb_idx = s;
        #1 r = iss_inv;
        idle_issue();
    endtask

    task automatic t_reset();
        logic r;
        next();
        check("R1", "ra_active after reset", ra_active, 1'b0);
        head_valid = 1; head_done = 0;
        #1 check("R9", "no pop without done in NORMAL", head_pop, 1'b0);
        head_valid = 0;
        probe_reg(6'd5, r);
        check("R12", "iss_inv in NORMAL", r, 1'b0);
    endtask

    task automatic t_enter();
        logic r;
        next();
        ra_enter = 1; trig_tag = 6'd5;
        next();
        ra_enter = 0;
        check("R1", "ra_active after enter", ra_active, 1'b1);
        probe_reg(6'd5, r);
        check("R2", "trigger dest flagged", r, 1'b1);
        probe_reg(6'd6, r);
        check("R2", "other reg clean", r, 1'b0);
    endtask

    task automatic t_trigger_head();
        next();
        head_valid = 1; head_inv = 0; head_done = 0;
        #1;
        check("R8", "trigger pops at once", head_pop, 1'b1);
        check("R9", "trigger pseudo", head_pseudo, 1'b1);
        check("R9", "trigger no commit", head_commit, 1'b0);
        next();
        #1 check("R7", "valid undone waits", head_pop, 1'b0);
        head_done = 1;
        #1 check("R7", "valid done pops", head_pop, 1'b1);
        check("R13", "exclusive outcomes", head_commit & head_pseudo, 1'b0);
        head_done = 0; head_inv = 1;
        #1 check("R7", "flagged pops at once", head_pop, 1'b1);
        check("R9", "flagged pops pseudo", head_pseudo, 1'b1);
        head_valid = 0; head_inv = 0;
    endtask

    task automatic t_propagate();
        logic r;
        next();
        iss_valid = 1; iss_src0_used = 0; iss_src0_tag = 6'd6;
        iss_src1_used = 1; iss_src1_tag = 6'd5; iss_dst_we = 1; iss_dst_tag = 6'd9;
        #1 check("R3", "src1 flagged -> inv", iss_inv, 1'b1);
        next();
        probe_reg(6'd9, r);
        check("R3", "dest flagged next cycle", r, 1'b1);
        next();
        iss_valid = 1; iss_src0_used = 0; iss_src0_tag = 6'd5;
        iss_src1_used = 1; iss_src1_tag = 6'd6; iss_dst_we = 1; iss_dst_tag = 6'd10;
        #1 check("R3", "unused flagged source ignored", iss_inv, 1'b0);
        next();
        probe_reg(6'd10, r);
        check("R4", "valid dest stays clean", r, 1'b0);
        next();
        wb_valid = 1; wb_dst_we = 1; wb_dst_tag = 6'd9;
        next();
        probe_reg(6'd9, r);
        check("R4", "valid writeback clears flag", r, 1'b0);
    endtask

    task automatic t_store();
        logic r;
        next();
        iss_valid = 1; iss_src0_used = 1; iss_src0_tag = 6'd5;
        iss_is_store = 1; iss_sb_idx = 4'd3;
        #1 check("R5", "store with flagged data", iss_inv, 1'b1);
        next();
        probe_sb(4'd3, r);
        check("R6", "forward from flagged slot", r, 1'b1);
        probe_sb(4'd2, r);
        check("R6", "forward from clean slot", r, 1'b0);
        next();
        wb_valid = 1; wb_is_store = 1; wb_sb_idx = 4'd3;
        next();
        probe_sb(4'd3, r);
        check("R5", "valid store clears slot", r, 1'b0);
    endtask

    task automatic t_exit();
        logic r;
        next();
        iss_valid = 1; iss_src0_used = 1; iss_src0_tag = 6'd5;
        iss_dst_we = 1; iss_dst_tag = 6'd11;
        next();
        iss_valid = 1; iss_src0_used = 1; iss_src0_tag = 6'd11;
        iss_is_store = 1; iss_sb_idx = 4'd4;
        next();
        ra_exit = 1;
        next();
        ra_exit = 0;
        check("R1", "ra_active low in DRAIN", ra_active, 1'b0);
        head_valid = 1; head_done = 1;
        #1 check("R11", "no pop in DRAIN", head_pop, 1'b0);
        head_valid = 0; head_done = 0;
        probe_reg(6'd5, r);
        check("R12", "no inv in DRAIN", r, 1'b0);
        next();
        head_valid = 1; head_inv = 1; head_done = 0;
        #1 check("R9", "NORMAL ignores head_inv", head_pop, 1'b0);
        head_done = 1;
        #1 check("R9", "NORMAL commit", head_commit, 1'b1);
        check("R9", "NORMAL no pseudo", head_pseudo, 1'b0);
        head_valid = 0; head_inv = 0; head_done = 0;
        ra_enter = 1; trig_tag = 6'd20;
        next();
        ra_enter = 0;
        probe_reg(6'd11, r);
        check("R10", "reg flag cleared by exit", r, 1'b0);
        probe_reg(6'd5, r);
        check("R10", "old trigger flag cleared", r, 1'b0);
        probe_sb(4'd4, r);
        check("R10", "slot flag cleared by exit", r, 1'b0);
        probe_reg(6'd20, r);
        check("R2", "new trigger flagged", r, 1'b1);
        next();
        ra_exit = 1;
        next();
        ra_exit = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_enter();
        t_trigger_head();
        t_propagate();
        t_store();
        t_exit();
        repeat (2) next();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule